// File: doc/BRIEF.md
# Periodic Self-Calibration Scheduler

This block decides when a pair of analog input paths leaves normal measurement and enters a self-calibration phase. A calibration can be started by a periodic timer counted in 100 ms ticks, by a forced-calibration rule, or by a manual request from the controller. A forced calibration happens when the controller keeps inhibiting calibration for too many intervals. One scheduler and one set of interval settings serve both channels, so both channels always calibrate together.

While a calibration phase runs, both process outputs read zero, a calibration status flag is high and the run indicator is off. During the phase, a stability test compares a measured input deviation against a tolerance. The phase completes only after a fixed number of consecutive stable ticks. While the input is unstable, the block holds the error and overload/underload flags. The analog switching itself is outside this block.

Top module: `selfcal_sched`

## Requirements
- R1: When not inhibited, a calibration starts in the clock cycle after the `intervalTicks`-th tick counted since reset or since the last calibration ended. An `intervalTicks` of 0 disables periodic starts.
- R2: While calibration is active, `chanAOut` and `chanBOut` are both 0. Otherwise they equal `chanAIn` and `chanBIn`.
- R3: `calActive` is 1 exactly while a calibration phase runs, and `runLed` is its inverse.
- R4: While `calInhibit` is 1, an elapsed interval does not start a calibration unless R5 applies.
- R5: While inhibited, the interval that would be the `forceIntervals`-th skipped one in a row starts a forced calibration. A `forceIntervals` of 0 never forces. The skip count clears whenever any calibration starts.
- R6: A rising edge on `manualReq` outside calibration starts a calibration in the next cycle, even while inhibited. A level held high starts only one calibration, and an edge during calibration is ignored.
- R7: A calibration ends in the cycle after the `CAL_TICKS`-th consecutive stable tick, with `CAL_TICKS` = 3 by default. The periodic count restarts from zero at the end.
- R8: With `stabTestEn` = 1, a cycle where `deviation` > `tolerance` during calibration discards the stable-tick progress. In such a cycle, `errFlag` and `overloadFlag` are 1 when `stabErrReportEn` = 1.
- R9: With `stabTestEn` = 0, every tick counts as stable. With `stabErrReportEn` = 0, `errFlag` and `overloadFlag` stay 0.
- R10: After reset, the block is not calibrating: `calActive` = 0, `runLed` = 1, and the outputs pass through the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick100ms | input | 1 | One-cycle pulse every 100 ms |
| calInhibit | input | 1 | Inhibits periodic calibration |
| manualReq | input | 1 | Manual calibration request, edge-detected |
| intervalTicks | input | IW (8) | Calibration interval in ticks |
| forceIntervals | input | FW (4) | Skipped intervals before a forced calibration |
| stabTestEn | input | 1 | Enables the stability test |
| stabErrReportEn | input | 1 | Enables reporting of stability errors |
| deviation | input | DW (12) | Measured input variation |
| tolerance | input | DW (12) | Allowed variation |
| chanAIn | input | DATA_W (16) | Channel A process value |
| chanBIn | input | DATA_W (16) | Channel B process value |
| chanAOut | output | DATA_W (16) | Channel A output, zero during calibration |
| chanBOut | output | DATA_W (16) | Channel B output, zero during calibration |
| calActive | output | 1 | Calibration status flag |
| runLed | output | 1 | Run indicator, off during calibration |
| errFlag | output | 1 | Stability error |
| overloadFlag | output | 1 | Overload/underload during unstable calibration |

## Verification
A corrupted interval or skip count shows at the ports as a calibration that begins one or more ticks early or late. The bench therefore checks `calActive` after every single tick, so an off-by-one shows within one tick of the expected start. A stuck phase counter shows as a calibration that ends too early or never ends. An edge detector that stays armed shows as a second calibration under a held manual request, within `CAL_TICKS` ticks of the first one ending. Both of these show within a few ticks of the stimulus.

// File: rtl/calsched_pkg.sv
package calsched_pkg;
  typedef struct packed {
    logic cntPeriod;
    logic clrPeriod;
    logic incSkip;
    logic clrSkip;
    logic cntDur;
    logic clrDur;
  } calStrobe_t;

  typedef enum logic {ST_RUN, ST_CAL} calState_t;
endpackage

// File: rtl/calsched_dp.sv
module calsched_dp
  import calsched_pkg::*;
#(
  parameter int IW        = 8,
  parameter int FW        = 4,
  parameter int DW        = 12,
  parameter int CAL_TICKS = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  calStrobe_t    strobe,
  input  logic [IW-1:0] intervalTicks,
  input  logic [FW-1:0] forceIntervals,
  input  logic          stabTestEn,
  input  logic [DW-1:0] deviation,
  input  logic [DW-1:0] tolerance,
  output logic          periodDone,
  output logic          forceDue,
  output logic          durDone,
  output logic          stable
);
  localparam int DUR_W = $clog2(CAL_TICKS + 1);
  localparam logic [FW-1:0] SKIP_MAX = {FW{1'b1}};

  logic [IW-1:0]    periodCnt;
  logic [FW-1:0]    skipCnt;
  logic [DUR_W-1:0] durCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (strobe.clrPeriod) begin
      periodCnt <= '0;
    end else if (strobe.cntPeriod && tick) begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      skipCnt <= '0;
    end else if (strobe.clrSkip) begin
      skipCnt <= '0;
    end else if (strobe.incSkip && skipCnt != SKIP_MAX) begin
      skipCnt <= skipCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      durCnt <= '0;
    end else if (strobe.clrDur) begin
      durCnt <= '0;
    end else if (strobe.cntDur && tick) begin
      durCnt <= durCnt + 1'b1;
    end
  end

  always_comb begin
    stable     = !stabTestEn || (deviation <= tolerance);
    periodDone = tick && (intervalTicks != '0) && (periodCnt >= intervalTicks - 1'b1);
    forceDue   = (forceIntervals != '0) &&
                 (({1'b0, skipCnt} + 1'b1) >= {1'b0, forceIntervals});
    durDone    = tick && stable && (durCnt == DUR_W'(CAL_TICKS - 1));
  end

  a_r7_dur_bound: assert property (@(posedge clk) disable iff (!rstN)
    durCnt <= DUR_W'(CAL_TICKS - 1));
endmodule

// File: rtl/calsched_ctrl.sv
module calsched_ctrl
  import calsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       manualReq,
  input  logic       calInhibit,
  input  logic       periodDone,
  input  logic       forceDue,
  input  logic       durDone,
  input  logic       stable,
  output calStrobe_t strobe,
  output logic       calActive
);
  calState_t state, stateNext;
  logic manualPrev;
  logic manualEdge;
  logic periodicGo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RUN;
      manualPrev <= 1'b0;
    end else begin
      state      <= stateNext;
      manualPrev <= manualReq;
    end
  end

  always_comb begin
    manualEdge = manualReq && !manualPrev;
    periodicGo = periodDone && (!calInhibit || forceDue);
    strobe     = '0;
    stateNext  = state;
    unique case (state)
      ST_RUN: begin
        strobe.cntPeriod = 1'b1;
        if (manualEdge || periodicGo) begin
          strobe.clrPeriod = 1'b1;
          strobe.clrSkip   = 1'b1;
          strobe.clrDur    = 1'b1;
          stateNext        = ST_CAL;
        end else if (periodDone) begin
          strobe.clrPeriod = 1'b1;
          strobe.incSkip   = 1'b1;
        end
      end
      ST_CAL: begin
        strobe.clrPeriod = 1'b1;
        if (!stable) begin
          strobe.clrDur = 1'b1;
        end else begin
          strobe.cntDur = 1'b1;
        end
        if (durDone) begin
          strobe.clrDur = 1'b1;
          stateNext     = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign calActive = (state == ST_CAL);

  a_r6_manual_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && manualReq && !manualPrev) |=> (state == ST_CAL));

  a_r7_exit_on_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAL && !durDone) |=> (state == ST_CAL));

  a_r8_hold_unstable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAL && !stable) |=> (state == ST_CAL));

  a_r4_inhibit_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && calInhibit && !manualEdge && !forceDue) |=> (state == ST_RUN));
endmodule

// File: rtl/selfcal_sched.sv
module selfcal_sched
  import calsched_pkg::*;
#(
  parameter int IW        = 8,
  parameter int FW        = 4,
  parameter int DW        = 12,
  parameter int DATA_W    = 16,
  parameter int CAL_TICKS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick100ms,
  input  logic              calInhibit,
  input  logic              manualReq,
  input  logic [IW-1:0]     intervalTicks,
  input  logic [FW-1:0]     forceIntervals,
  input  logic              stabTestEn,
  input  logic              stabErrReportEn,
  input  logic [DW-1:0]     deviation,
  input  logic [DW-1:0]     tolerance,
  input  logic [DATA_W-1:0] chanAIn,
  input  logic [DATA_W-1:0] chanBIn,
  output logic [DATA_W-1:0] chanAOut,
  output logic [DATA_W-1:0] chanBOut,
  output logic              calActive,
  output logic              runLed,
  output logic              errFlag,
  output logic              overloadFlag
);
  calStrobe_t strobe;
  logic periodDone, forceDue, durDone, stable;

  calsched_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .manualReq  (manualReq),
    .calInhibit (calInhibit),
    .periodDone (periodDone),
    .forceDue   (forceDue),
    .durDone    (durDone),
    .stable     (stable),
    .strobe     (strobe),
    .calActive  (calActive)
  );

  calsched_dp #(
    .IW(IW), .FW(FW), .DW(DW), .CAL_TICKS(CAL_TICKS)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .tick           (tick100ms),
    .strobe         (strobe),
    .intervalTicks  (intervalTicks),
    .forceIntervals (forceIntervals),
    .stabTestEn     (stabTestEn),
    .deviation      (deviation),
    .tolerance      (tolerance),
    .periodDone     (periodDone),
    .forceDue       (forceDue),
    .durDone        (durDone),
    .stable         (stable)
  );

  always_comb begin
    chanAOut     = calActive ? '0 : chanAIn;
    chanBOut     = calActive ? '0 : chanBIn;
    runLed       = !calActive;
    errFlag      = calActive && !stable && stabErrReportEn;
    overloadFlag = errFlag;
  end
endmodule

// File: tb/selfcal_sched_tb_top.sv
module selfcal_sched_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick100ms = 1'b0;
  logic calInhibit = 1'b0;
  logic manualReq = 1'b0;
  logic [7:0]  intervalTicks = '0;
  logic [3:0]  forceIntervals = '0;
  logic stabTestEn = 1'b1;
  logic stabErrReportEn = 1'b1;
  logic [11:0] deviation = '0;
  logic [11:0] tolerance = 12'd10;
  logic [15:0] chanAIn = 16'h1234;
  logic [15:0] chanBIn = 16'hABCD;
  logic [15:0] chanAOut, chanBOut;
  logic calActive, runLed, errFlag, overloadFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  selfcal_sched dut_i (
    .clk(clk), .rstN(rstN), .tick100ms(tick100ms), .calInhibit(calInhibit),
    .manualReq(manualReq), .intervalTicks(intervalTicks), .forceIntervals(forceIntervals),
    .stabTestEn(stabTestEn), .stabErrReportEn(stabErrReportEn), .deviation(deviation),
    .tolerance(tolerance), .chanAIn(chanAIn), .chanBIn(chanBIn), .chanAOut(chanAOut),
    .chanBOut(chanBOut), .calActive(calActive), .runLed(runLed), .errFlag(errFlag),
    .overloadFlag(overloadFlag)
  );

  // interval, forceIntervals, inhibit, tick at which calibration starts (0 = never)
  localparam int VEC[7][4] = '{
    '{3, 0, 0, 3}, '{5, 2, 0, 5}, '{2, 3, 1, 6}, '{4, 1, 1, 4},
    '{1, 2, 1, 2}, '{2, 0, 1, 0}, '{0, 1, 0, 0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic tickOnce();
    tick100ms = 1'b1;
    @(negedge clk);
    tick100ms = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R10 reset state
    doReset();
    check("R10 calActive", calActive, 0);
    check("R10 runLed", runLed, 1);
    check("R10 chanAOut", chanAOut, 16'h1234);
    check("R10 chanBOut", chanBOut, 16'hABCD);
    check("R10 errFlag", errFlag, 0);

    // R1 R4 R5 vector table
    for (int v = 0; v < 7; v++) begin
      intervalTicks  = 8'(VEC[v][0]);
      forceIntervals = 4'(VEC[v][1]);
      calInhibit     = VEC[v][2][0];
      doReset();
      for (int k = 1; k <= ((VEC[v][3] == 0) ? 20 : VEC[v][3]); k++) begin
        tickOnce();
        check($sformatf("R1/R4/R5 vec%0d tick%0d", v, k), calActive, (k == VEC[v][3]) ? 1 : 0);
      end
    end

    // R2 R3 outputs during calibration, R7 completion and period restart
    intervalTicks = 8'd3; forceIntervals = '0; calInhibit = 1'b0;
    doReset();
    repeat (3) tickOnce();
    check("R3 calActive", calActive, 1);
    check("R3 runLed", runLed, 0);
    check("R2 chanAOut zero", chanAOut, 0);
    check("R2 chanBOut zero", chanBOut, 0);
    repeat (2) tickOnce();
    check("R7 active after 2 ticks", calActive, 1);
    tickOnce();
    check("R7 done after 3 ticks", calActive, 0);
    check("R2 chanAOut restored", chanAOut, 16'h1234);
    repeat (2) tickOnce();
    check("R7 period restart tick2", calActive, 0);
    tickOnce();
    check("R7 period restart tick3", calActive, 1);

    // R6 manual held high and while inhibited
    intervalTicks = 8'd0; calInhibit = 1'b1;
    doReset();
    manualReq = 1'b1;
    @(negedge clk);
    check("R6 manual start inhibited", calActive, 1);
    repeat (3) tickOnce();
    check("R6 manual cal ends", calActive, 0);
    repeat (4) @(negedge clk);
    check("R6 held level no restart", calActive, 0);
    manualReq = 1'b0;
    @(negedge clk);
    manualReq = 1'b1;
    @(negedge clk);
    check("R6 second edge", calActive, 1);
    manualReq = 1'b0;
    @(negedge clk);
    manualReq = 1'b1;
    tickOnce();
    manualReq = 1'b0;
    repeat (2) tickOnce();
    check("R6 edge in cal ignored", calActive, 0);
    @(negedge clk);
    check("R6 no pending start", calActive, 0);

    // R8 progress discarded by instability, error flags
    manualReq = 1'b1;
    @(negedge clk);
    manualReq = 1'b0;
    repeat (2) tickOnce();
    deviation = 12'd50;
    @(negedge clk);
    check("R8 errFlag", errFlag, 1);
    check("R8 overloadFlag", overloadFlag, 1);
    repeat (4) tickOnce();
    check("R8 held unstable", calActive, 1);
    deviation = 12'd5;
    repeat (2) tickOnce();
    check("R8 progress restarted", calActive, 1);
    check("R8 errFlag clear", errFlag, 0);
    tickOnce();
    check("R8 completes", calActive, 0);

    // R9 report disable and test disable
    manualReq = 1'b1;
    @(negedge clk);
    manualReq = 1'b0;
    deviation = 12'd99;
    stabErrReportEn = 1'b0;
    tickOnce();
    check("R9 errFlag masked", errFlag, 0);
    check("R9 overload masked", overloadFlag, 0);
    check("R9 still active", calActive, 1);
    stabTestEn = 1'b0;
    repeat (2) tickOnce();
    check("R9 test off active", calActive, 1);
    tickOnce();
    check("R9 test off completes", calActive, 0);

    finishRun();
  end
endmodule